// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the host side of a byte-wide flash device. It samples the bus synchronously: address, write data and a write strobe. Each rising edge of the strobe counts as one host write. Writes are decoded against strict multi-cycle unlock sequences. Each step must carry an exact address and data pair. The decoder then selects one of three device modes: array read, identifier read or automatic chip erase. When a complete chip-erase sequence is seen, it emits a one-cycle start pulse to a separate erase sequencer. It then stays in erase mode until that sequencer reports completion.

Reads are combinational. In array mode the read bus passes the array data through. In identifier mode it returns fixed codes chosen by the two low address bits. The abort byte F0h returns the decoder to array read from any idle mode at any address. During an erase, the abort byte is honoured only after the sequencer has reported a failure.

The sequence state machine has six states:

- `SQ_IDLE` waits for the first unlock.
- `SQ_UNLK1` follows AAh written at 555h.
- `SQ_UNLK2` follows 55h written at 2AAh.
- `SQ_SETUP` follows 80h written at 555h.
- `SQ_SUNLK1` and `SQ_SUNLK2` repeat the two unlock steps after the setup write.

Each matching write moves the state machine one step along IDLE → UNLK1 → UNLK2 → SETUP → SUNLK1 → SUNLK2. The following writes end a sequence and return it to IDLE:

- 90h at 555h in UNLK2 selects identifier mode.
- 10h at 555h in SUNLK2 selects erase mode and fires the start pulse.
- Any non-matching write.
- An accepted abort.
- Completion of an erase.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (array read; identifier is 1, erase is 2, and 3 never occurs), `erase_start` is low and `rdata` equals `array_rdata`.
- R2: A write is taken only on a rising edge of `wr_strobe`. Holding the strobe high for several cycles, even while address or data change, counts as a single write.
- R3: The writes AAh@555h, 55h@2AAh and 90h@555h, in that order, set `mode` to 1 in the cycle after the third strobe edge.
- R4: In identifier mode, `rdata` is C2h when addr[1:0]=00, D5h when addr[1:0]=01, and 00h for 10 and 11, whatever the upper address bits are.
- R5: In array mode (and erase mode), `rdata` equals `array_rdata` for every address.
- R6: Outside erase mode, writing F0h at any address sets `mode` to 0 and discards any partial sequence.
- R7: A write that does not match the next expected step returns the sequence to idle. Later writes that would have completed the broken sequence have no effect.
- R8: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raise `erase_start` for exactly one cycle, in the cycle after the last strobe edge. `mode` becomes 2 at the same time. Any other final byte starts nothing.
- R9: While `mode` is 2 and no failure has been reported, every write is ignored, including F0h and complete command sequences. `erase_start` does not fire again.
- R10: An `erase_done` pulse in erase mode sets `mode` to 0 in the following cycle.
- R11: An `erase_fail` pulse in erase mode is remembered. `mode` stays 2 until F0h is written, and then becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_strobe | input | 1 | Host write strobe, active high; its rising edge marks a write |
| addr | input | ADDR_W | Host address for writes and reads |
| wdata | input | 8 | Host write data |
| array_rdata | input | 8 | Data from the storage array |
| erase_done | input | 1 | Erase sequencer reports successful completion |
| erase_fail | input | 1 | Erase sequencer reports a failure |
| rdata | output | 8 | Read data towards the host |
| mode | output | 2 | Current mode: 0 array, 1 identifier, 2 erase |
| erase_start | output | 1 | One-cycle pulse that launches the chip erase |

## Verification
The bench builds the decoder with its default 11-bit address. At that width, every one of the 2048 addresses can be read back in both array and identifier mode, so the code table and the pass-through are checked over the complete address space. The width also allows a sweep of all 256 command bytes at the third cycle of an unlocked sequence, which separates the one identifier byte and the abort byte from every other value. Directed sequences add the cases the sweeps cannot reach: held strobes, broken unlocks, a wrong final erase byte, and the erase lockout with and without a reported failure.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int CMD_W = 8;

    typedef enum logic [1:0] {
        MODE_ARRAY = 2'd0,
        MODE_ID    = 2'd1,
        MODE_ERASE = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_UNLK1  = 3'd1,
        SQ_UNLK2  = 3'd2,
        SQ_SETUP  = 3'd3,
        SQ_SUNLK1 = 3'd4,
        SQ_SUNLK2 = 3'd5
    } seq_e;

    localparam logic [CMD_W-1:0] BYTE_UNLK_A = 8'hAA;
    localparam logic [CMD_W-1:0] BYTE_UNLK_B = 8'h55;
    localparam logic [CMD_W-1:0] BYTE_IDENT  = 8'h90;
    localparam logic [CMD_W-1:0] BYTE_SETUP  = 8'h80;
    localparam logic [CMD_W-1:0] BYTE_CHIP   = 8'h10;
    localparam logic [CMD_W-1:0] BYTE_ABORT  = 8'hF0;

endpackage

// File: rtl/wr_edge_detect.sv
module wr_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic wr_evt
);

    logic strobe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= strobe;
        end
    end

    assign wr_evt = strobe & ~strobe_q;

endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W   = 11,
    parameter logic [ADDR_W-1:0] ADDR_CMD = 'h555,
    parameter logic [ADDR_W-1:0] ADDR_ALT = 'h2AA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CMD_W-1:0]  wr_data,
    input  logic              erase_done,
    input  logic              erase_fail,
    output mode_e             mode_o,
    output logic              start_o,
    output logic              fail_o
);

    seq_e  seq_q,  seq_n;
    mode_e mode_q, mode_n;
    logic  start_q, start_n;
    logic  fail_q,  fail_n;

    logic hit_cmd_aa, hit_alt_55, hit_cmd_90, hit_cmd_80, hit_cmd_10, is_abort;

    assign hit_cmd_aa = wr_evt && (wr_addr == ADDR_CMD) && (wr_data == BYTE_UNLK_A);
    assign hit_alt_55 = wr_evt && (wr_addr == ADDR_ALT) && (wr_data == BYTE_UNLK_B);
    assign hit_cmd_90 = wr_evt && (wr_addr == ADDR_CMD) && (wr_data == BYTE_IDENT);
    assign hit_cmd_80 = wr_evt && (wr_addr == ADDR_CMD) && (wr_data == BYTE_SETUP);
    assign hit_cmd_10 = wr_evt && (wr_addr == ADDR_CMD) && (wr_data == BYTE_CHIP);
    assign is_abort   = wr_evt && (wr_data == BYTE_ABORT);

    // Next-state process
    always_comb begin
        seq_n   = seq_q;
        mode_n  = mode_q;
        start_n = 1'b0;
        fail_n  = fail_q;

        if (mode_q == MODE_ERASE) begin
            if (erase_fail) begin
                fail_n = 1'b1;
            end
            if (erase_done) begin
                mode_n = MODE_ARRAY;
                fail_n = 1'b0;
                seq_n  = SQ_IDLE;
            end else if (is_abort && fail_q) begin
                mode_n = MODE_ARRAY;
                fail_n = 1'b0;
                seq_n  = SQ_IDLE;
            end
        end else if (wr_evt) begin
            if (is_abort) begin
                mode_n = MODE_ARRAY;
                seq_n  = SQ_IDLE;
            end else begin
                unique case (seq_q)
                    SQ_IDLE:   seq_n = hit_cmd_aa ? SQ_UNLK1 : SQ_IDLE;
                    SQ_UNLK1:  seq_n = hit_alt_55 ? SQ_UNLK2 : SQ_IDLE;
                    SQ_UNLK2: begin
                        if (hit_cmd_90) begin
                            mode_n = MODE_ID;
                            seq_n  = SQ_IDLE;
                        end else if (hit_cmd_80) begin
                            seq_n  = SQ_SETUP;
                        end else begin
                            seq_n  = SQ_IDLE;
                        end
                    end
                    SQ_SETUP:  seq_n = hit_cmd_aa ? SQ_SUNLK1 : SQ_IDLE;
                    SQ_SUNLK1: seq_n = hit_alt_55 ? SQ_SUNLK2 : SQ_IDLE;
                    SQ_SUNLK2: begin
                        if (hit_cmd_10) begin
                            mode_n  = MODE_ERASE;
                            start_n = 1'b1;
                        end
                        seq_n = SQ_IDLE;
                    end
                    default:   seq_n = SQ_IDLE;
                endcase
            end
        end
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q   <= SQ_IDLE;
            mode_q  <= MODE_ARRAY;
            start_q <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            seq_q   <= seq_n;
            mode_q  <= mode_n;
            start_q <= start_n;
            fail_q  <= fail_n;
        end
    end

    // Output process
    always_comb begin
        mode_o  = mode_q;
        start_o = start_q;
        fail_o  = fail_q;
    end

endmodule

// File: rtl/id_read_mux.sv
module id_read_mux
    import flash_cmd_pkg::*;
#(
    parameter logic [CMD_W-1:0] MFR_CODE = 8'hC2,
    parameter logic [CMD_W-1:0] DEV_CODE = 8'hD5,
    parameter logic [CMD_W-1:0] ID_FILL  = 8'h00
) (
    input  logic             id_sel,
    input  logic [1:0]       addr_lo,
    input  logic [CMD_W-1:0] array_rdata,
    output logic [CMD_W-1:0] rdata
);

    logic [CMD_W-1:0] id_byte;

    always_comb begin
        unique case (addr_lo)
            2'b00:   id_byte = MFR_CODE;
            2'b01:   id_byte = DEV_CODE;
            default: id_byte = ID_FILL;
        endcase
        rdata = id_sel ? id_byte : array_rdata;
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W   = 11,
    parameter logic [ADDR_W-1:0] ADDR_CMD = 'h555,
    parameter logic [ADDR_W-1:0] ADDR_ALT = 'h2AA,
    parameter logic [7:0]        MFR_CODE = 8'hC2,
    parameter logic [7:0]        DEV_CODE = 8'hD5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [7:0]        array_rdata,
    input  logic              erase_done,
    input  logic              erase_fail,
    output logic [7:0]        rdata,
    output logic [1:0]        mode,
    output logic              erase_start
);

    logic  wr_evt;
    mode_e mode_st;
    logic  fail_seen;

    wr_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (wr_strobe),
        .wr_evt (wr_evt)
    );

    cmd_seq_fsm #(
        .ADDR_W   (ADDR_W),
        .ADDR_CMD (ADDR_CMD),
        .ADDR_ALT (ADDR_ALT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_evt     (wr_evt),
        .wr_addr    (addr),
        .wr_data    (wdata),
        .erase_done (erase_done),
        .erase_fail (erase_fail),
        .mode_o     (mode_st),
        .start_o    (erase_start),
        .fail_o     (fail_seen)
    );

    id_read_mux #(
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE),
        .ID_FILL  (8'h00)
    ) u_idmux (
        .id_sel      (mode_st == MODE_ID),
        .addr_lo     (addr[1:0]),
        .array_rdata (array_rdata),
        .rdata       (rdata)
    );

    assign mode = mode_st;

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
    parameter int         ADDR_W   = 11,
    parameter logic [7:0] MFR_CODE = 8'hC2,
    parameter logic [7:0] DEV_CODE = 8'hD5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        array_rdata,
    input logic              erase_done,
    input logic [7:0]        rdata,
    input logic [1:0]        mode,
    input logic              erase_start,
    input logic              fail_seen
);

    p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'd3);

    p_mfr_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && addr[1:0] == 2'b00) |-> rdata == MFR_CODE);

    p_dev_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && addr[1:0] == 2'b01) |-> rdata == DEV_CODE);

    p_array_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd1) |-> rdata == array_rdata);

    p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);

    p_start_in_erase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> mode == 2'd2);

    p_erase_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !erase_done && !fail_seen) |=> mode == 2'd2);

    p_done_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && erase_done) |=> mode == 2'd0);

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
    .ADDR_W   (ADDR_W),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .array_rdata (array_rdata),
    .erase_done  (erase_done),
    .rdata       (rdata),
    .mode        (mode),
    .erase_start (erase_start),
    .fail_seen   (fail_seen)
);

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;

    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_strobe = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    array_rdata;
    logic          erase_done = 1'b0;
    logic          erase_fail = 1'b0;
    logic [7:0]    rdata;
    logic [1:0]    mode;
    logic          erase_start;

    int vectors = 0;
    int fails = 0;
    logic saw;

    always #10 clk = ~clk;

    assign array_rdata = addr[7:0] ^ {5'b0, addr[10:8]} ^ 8'h3C;

    flash_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .addr(addr),
        .wdata(wdata), .array_rdata(array_rdata), .erase_done(erase_done),
        .erase_fail(erase_fail), .rdata(rdata), .mode(mode),
        .erase_start(erase_start)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // One write: strobe rises, held one cycle; saw = erase_start after the edge
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, output logic s);
        @(negedge clk);
        addr = a; wdata = d; wr_strobe = 1'b1;
        @(negedge clk);
        s = erase_start;
        wr_strobe = 1'b0;
        @(negedge clk);
        check("R8 pulse width", {31'b0, erase_start}, 32'd0);
    endtask

    task automatic erase_seq(input logic [7:0] last, output logic s);
        logic t;
        wr(11'h555, 8'hAA, t); wr(11'h2AA, 8'h55, t); wr(11'h555, 8'h80, t);
        wr(11'h555, 8'hAA, t); wr(11'h2AA, 8'h55, t);
        wr(11'h555, last, s);
    endtask

    task automatic id_seq();
        logic t;
        wr(11'h555, 8'hAA, t); wr(11'h2AA, 8'h55, t); wr(11'h555, 8'h90, t);
    endtask

    task automatic sweep_reads(input bit id_mode, input string req);
        for (int a = 0; a < (1 << AW); a++) begin
            logic [7:0] exp;
            addr = a[AW-1:0];
            #1;
            if (id_mode)
                exp = (a[1:0] == 2'b00) ? 8'hC2 : (a[1:0] == 2'b01) ? 8'hD5 : 8'h00;
            else
                exp = a[7:0] ^ {5'b0, a[10:8]} ^ 8'h3C;
            check(req, {24'b0, rdata}, {24'b0, exp});
        end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 mode", {30'b0, mode}, 32'd0);
        check("R1 start", {31'b0, erase_start}, 32'd0);
        check("R1 rdata", {24'b0, rdata}, {24'b0, array_rdata});
        rst_n = 1'b1;
        @(negedge clk);

        // R5 array pass-through over every address
        sweep_reads(1'b0, "R5 array read");

        // R3 identifier entry
        id_seq();
        check("R3 id mode", {30'b0, mode}, 32'd1);
        // R4 code table over every address
        sweep_reads(1'b1, "R4 id code");

        // R6 abort at arbitrary address
        wr(11'h123, 8'hF0, saw);
        check("R6 abort to array", {30'b0, mode}, 32'd0);
        // R6 abort clears a partial sequence
        wr(11'h555, 8'hAA, saw); wr(11'h2AA, 8'h55, saw);
        wr(11'h007, 8'hF0, saw); wr(11'h555, 8'h90, saw);
        check("R6 partial discarded", {30'b0, mode}, 32'd0);

        // R2 held strobe counts once
        @(negedge clk);
        addr = 11'h555; wdata = 8'hAA; wr_strobe = 1'b1;
        repeat (3) @(negedge clk);
        addr = 11'h2AA; wdata = 8'h55;
        repeat (2) @(negedge clk);
        wr_strobe = 1'b0;
        @(negedge clk);
        wr(11'h2AA, 8'h55, saw); wr(11'h555, 8'h90, saw);
        check("R2 single edge", {30'b0, mode}, 32'd1);
        wr(11'h000, 8'hF0, saw);

        // R7 wrong address in second step
        wr(11'h555, 8'hAA, saw); wr(11'h2AB, 8'h55, saw); wr(11'h555, 8'h90, saw);
        check("R7 bad address", {30'b0, mode}, 32'd0);
        // R7 repeated first step breaks sequence
        wr(11'h555, 8'hAA, saw); wr(11'h2AA, 8'h55, saw); wr(11'h555, 8'hAA, saw);
        wr(11'h2AA, 8'h55, saw); wr(11'h555, 8'h90, saw);
        check("R7 broken restart", {30'b0, mode}, 32'd0);

        // R3/R6/R7 sweep all third-cycle bytes
        for (int d = 0; d < 256; d++) begin
            wr(11'h555, 8'hAA, saw); wr(11'h2AA, 8'h55, saw);
            wr(11'h555, d[7:0], saw);
            check("R3 third byte", {30'b0, mode}, (d == 8'h90) ? 32'd1 : 32'd0);
            check("R8 no start", {31'b0, saw}, 32'd0);
            wr(11'h000, 8'hF0, saw);
            check("R6 sweep abort", {30'b0, mode}, 32'd0);
        end

        // R8 wrong final byte
        erase_seq(8'h30, saw);
        check("R8 bad final no start", {31'b0, saw}, 32'd0);
        check("R8 bad final mode", {30'b0, mode}, 32'd0);

        // R8 good erase
        erase_seq(8'h10, saw);
        check("R8 start pulse", {31'b0, saw}, 32'd1);
        check("R8 erase mode", {30'b0, mode}, 32'd2);

        // R9 lockout
        id_seq();
        check("R9 id ignored", {30'b0, mode}, 32'd2);
        wr(11'h555, 8'hF0, saw);
        check("R9 abort ignored", {30'b0, mode}, 32'd2);
        erase_seq(8'h10, saw);
        check("R9 no restart", {31'b0, saw}, 32'd0);
        check("R9 still erase", {30'b0, mode}, 32'd2);
        sweep_reads(1'b0, "R5 read in erase");

        // R10 completion
        @(negedge clk); erase_done = 1'b1;
        @(negedge clk); erase_done = 1'b0;
        check("R10 done exit", {30'b0, mode}, 32'd0);

        // R11 failure then abort
        erase_seq(8'h10, saw);
        check("R11 erase entry", {30'b0, mode}, 32'd2);
        @(negedge clk); erase_fail = 1'b1;
        @(negedge clk); erase_fail = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 stays erase", {30'b0, mode}, 32'd2);
        id_seq();
        check("R11 cmds still ignored", {30'b0, mode}, 32'd2);
        wr(11'h3FF, 8'hF0, saw);
        check("R11 abort accepted", {30'b0, mode}, 32'd0);
        id_seq();
        check("R11 decoder live", {30'b0, mode}, 32'd1);

        finish_run();
    end

endmodule